// File: doc/BRIEF.md
# Daisy-Chained TDM Slot Port

This block is the serial side of one device on a time-division-multiplexed audio bus. Several identical devices share one serial data line, and each has a fixed-length slot. The slot's position in the frame is not set by a counter offset. It is passed along a chain. A device takes the bus when its grant input rises. It gives the bus up by pulsing its release output during the final bit of its slot. That output feeds the grant input of the next device. The first device in the chain has its grant input tied to the frame sync. The bit clock and the frame sync come from outside the block.

During its slot the device shifts a word out, MSB first, on rising bit-clock edges. It also samples a word in, MSB first, on falling edges. A data/control select is captured when the slot is granted. It decides whether the received word is stored in the control register or in the data capture register. The transmitted word is taken from the parallel transmit input in data mode, and from the current control register in control mode. Power-down forces the control register to its default value, keeps the port off the bus, and makes the release output follow the grant input directly. The active-low reset loads the defaults.

The slot sequencer has three states:
- ST_IDLE waits for a grant.
- ST_SHIFT counts the bits of the slot.
- ST_DOWN is held while power-down is active.

Its transitions are:
- IDLE→SHIFT on a grant edge.
- SHIFT→SHIFT on each bit. A grant edge restarts the count.
- SHIFT→IDLE after the last bit, or when frame sync rises mid-slot with no grant.
- any→DOWN while power-down is high.
- DOWN→IDLE once power-down is released.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, ctrl_q equals CTRL_INIT, data_q is all zeros, and sdout_oe and tsout are low.
- R2: A rising edge of tsin, sampled at a rising bit-clock edge, starts the slot in the bit period that follows. sdout_oe is then high for exactly SLOT_BITS bit periods.
- R3: During the slot, sdout carries the transmit word MSB first and changes only after rising edges. The transmit word is tx_data when dc_sel was high at the grant edge, and the current ctrl_q when dc_sel was low. Outside the slot, sdout is low.
- R4: sdin is sampled on each falling edge of the slot, MSB first. One rising edge after the last bit, the full word is loaded into data_q if dc_sel was high at the grant edge, or into ctrl_q if it was low. The other register is left unchanged.
- R5: tsout is high during exactly the last bit period of the slot, and low at all other times outside power-down.
- R6: A rising edge of fsync that arrives mid-slot, without a grant edge on the same clock, abandons the slot. sdout_oe drops at once, and neither register is updated.
- R7: While pdn is high, sdout_oe is low and tsout equals tsin combinationally. After one rising edge with pdn high, ctrl_q equals CTRL_INIT.
- R8: A grant is edge based. If tsin (and so fsync) stays high beyond the slot, no second slot is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock. Output changes on the rising edge; input is sampled on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| pdn | input | 1 | Power-down, active high. |
| fsync | input | 1 | Frame sync. A rising edge marks a new frame. |
| tsin | input | 1 | Slot grant from the previous device, or from fsync for the first device. |
| dc_sel | input | 1 | High selects a data slot; low selects a control slot. Captured at the grant edge. |
| sdin | input | 1 | Serial data in. |
| tx_data | input | SLOT_BITS | Word sent in data mode. |
| sdout | output | 1 | Serial data out. Low when not driven. |
| sdout_oe | output | 1 | Output enable for sdout (the tri-state control). |
| tsout | output | 1 | Slot release pulse to the next device. |
| ctrl_q | output | SLOT_BITS | Control register. |
| data_q | output | SLOT_BITS | Data capture register. |

## Verification
The bench builds two instances with SLOT_BITS=16 and CTRL_INIT=16'hA5C3. They are chained so that the second device's grant is the first device's release, which makes a 32-bit frame. The short slot makes the last-bit release, the immediate hand-over and a mid-slot frame sync cheap to reach many times. Random frame-sync hold lengths, up to two bits before the end of the frame, exercise edge-based granting. A second device in the chain checks that release and grant line up with no gap and no overlap. It also shows power-down propagating along the chain.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DOWN  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_slot_pkg::*;
#(
    parameter int SLOT_BITS = 64
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic pdn,
    input  logic fsync,
    input  logic tsin,
    output logic slot_start,
    output logic shift_en,
    output logic commit,
    output logic slot_oe,
    output logic release_o
);
    localparam int CNT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_BITS - 1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tsin_q, fsync_q;
    logic             grant, fs_rise, in_slot, at_last;

    assign grant   = tsin & ~tsin_q;
    assign fs_rise = fsync & ~fsync_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tsin_q  <= 1'b0;
            fsync_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tsin_q  <= tsin;
            fsync_q <= fsync;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pdn) begin
            state_d = ST_DOWN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_DOWN: begin
                    state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (grant) begin
                        state_d = ST_SHIFT;
                        cnt_d   = '0;
                    end
                end
                ST_SHIFT: begin
                    if (grant) begin
                        cnt_d = '0;
                    end else if (cnt_q == LAST_BIT || fs_rise) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        in_slot    = (state_q == ST_SHIFT);
        at_last    = in_slot && (cnt_q == LAST_BIT);
        slot_start = !pdn && grant && (state_q != ST_DOWN);
        shift_en   = in_slot;
        commit     = at_last && !pdn;
        slot_oe    = in_slot && !pdn;
        release_o  = pdn ? tsin : at_last;
    end
endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter #(
    parameter int SLOT_BITS = 64
) (
    input  logic                 bclk,
    input  logic                 rst_n,
    input  logic                 sdin,
    input  logic                 load,
    input  logic                 shift_en,
    input  logic [SLOT_BITS-1:0] load_word,
    output logic                 tx_bit,
    output logic [SLOT_BITS-1:0] rx_word
);
    logic                 rx_bit;
    logic [SLOT_BITS-1:0] rx_sh;
    logic [SLOT_BITS-1:0] tx_sh;

    // Input capture on the falling edge, mid bit period.
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) rx_bit <= 1'b0;
        else        rx_bit <= sdin;
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh <= '0;
            tx_sh <= '0;
        end else begin
            if (shift_en) rx_sh <= rx_word;
            if (load)          tx_sh <= load_word;
            else if (shift_en) tx_sh <= {tx_sh[SLOT_BITS-2:0], 1'b0};
        end
    end

    assign rx_word = {rx_sh[SLOT_BITS-2:0], rx_bit};
    assign tx_bit  = tx_sh[SLOT_BITS-1];
endmodule

// File: rtl/tdm_slot_regs.sv
module tdm_slot_regs #(
    parameter int                   SLOT_BITS = 64,
    parameter logic [SLOT_BITS-1:0] CTRL_INIT = '0
) (
    input  logic                 bclk,
    input  logic                 rst_n,
    input  logic                 pdn,
    input  logic                 slot_start,
    input  logic                 dc_sel,
    input  logic                 commit,
    input  logic [SLOT_BITS-1:0] rx_word,
    output logic                 dc_q,
    output logic [SLOT_BITS-1:0] ctrl_q,
    output logic [SLOT_BITS-1:0] data_q
);
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q   <= 1'b0;
            ctrl_q <= CTRL_INIT;
            data_q <= '0;
        end else begin
            if (slot_start) dc_q <= dc_sel;
            if (pdn)                 ctrl_q <= CTRL_INIT;
            else if (commit && !dc_q) ctrl_q <= rx_word;
            if (commit && dc_q) data_q <= rx_word;
        end
    end
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
    parameter int                   SLOT_BITS = 64,
    parameter logic [SLOT_BITS-1:0] CTRL_INIT = 64'h0000_00C0_0000_0001
) (
    input  logic                 bclk,
    input  logic                 rst_n,
    input  logic                 pdn,
    input  logic                 fsync,
    input  logic                 tsin,
    input  logic                 dc_sel,
    input  logic                 sdin,
    input  logic [SLOT_BITS-1:0] tx_data,
    output logic                 sdout,
    output logic                 sdout_oe,
    output logic                 tsout,
    output logic [SLOT_BITS-1:0] ctrl_q,
    output logic [SLOT_BITS-1:0] data_q
);
    logic                 slot_start, shift_en, commit, slot_oe, tx_bit, dc_q;
    logic [SLOT_BITS-1:0] rx_word, load_word;

    assign load_word = dc_sel ? tx_data : ctrl_q;

    tdm_slot_fsm #(.SLOT_BITS(SLOT_BITS)) u_fsm (
        .bclk(bclk), .rst_n(rst_n), .pdn(pdn), .fsync(fsync), .tsin(tsin),
        .slot_start(slot_start), .shift_en(shift_en), .commit(commit),
        .slot_oe(slot_oe), .release_o(tsout)
    );

    tdm_slot_shifter #(.SLOT_BITS(SLOT_BITS)) u_shift (
        .bclk(bclk), .rst_n(rst_n), .sdin(sdin), .load(slot_start),
        .shift_en(shift_en), .load_word(load_word), .tx_bit(tx_bit),
        .rx_word(rx_word)
    );

    tdm_slot_regs #(.SLOT_BITS(SLOT_BITS), .CTRL_INIT(CTRL_INIT)) u_regs (
        .bclk(bclk), .rst_n(rst_n), .pdn(pdn), .slot_start(slot_start),
        .dc_sel(dc_sel), .commit(commit), .rx_word(rx_word), .dc_q(dc_q),
        .ctrl_q(ctrl_q), .data_q(data_q)
    );

    assign sdout_oe = slot_oe;
    assign sdout    = slot_oe & tx_bit;
endmodule

// File: rtl/tdm_slot_port_checker.sv
module tdm_slot_port_checker #(
    parameter int                   SLOT_BITS = 64,
    parameter logic [SLOT_BITS-1:0] CTRL_INIT = '0
) (
    input logic                 bclk,
    input logic                 rst_n,
    input logic                 pdn,
    input logic                 tsin,
    input logic                 sdout_oe,
    input logic                 tsout,
    input logic [SLOT_BITS-1:0] ctrl_q,
    input logic [SLOT_BITS-1:0] data_q
);
    assert_release_in_slot_R5: assert property (@(posedge bclk) disable iff (!rst_n)
        (!pdn && tsout) |-> sdout_oe);

    assert_release_ends_slot_R5: assert property (@(posedge bclk) disable iff (!rst_n)
        (!pdn && tsout) |=> (!sdout_oe || $rose(tsin)));

    assert_grant_starts_R2: assert property (@(posedge bclk) disable iff (!rst_n)
        (!pdn && $rose(tsin)) |=> (sdout_oe || pdn));

    assert_down_quiet_R7: assert property (@(posedge bclk) disable iff (!rst_n)
        pdn |-> (!sdout_oe && tsout == tsin));

    assert_down_defaults_R7: assert property (@(posedge bclk) disable iff (!rst_n)
        pdn |=> (ctrl_q == CTRL_INIT));

    assert_data_only_at_slot_end_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        !$stable(data_q) |-> $past(sdout_oe));
endmodule

bind tdm_slot_port tdm_slot_port_checker #(
    .SLOT_BITS(SLOT_BITS), .CTRL_INIT(CTRL_INIT)
) u_chk (.*);

// File: tb/tdm_slot_port_bench.sv
module tdm_slot_port_bench;
    localparam int         W     = 16;
    localparam logic [W-1:0] INIT = 16'hA5C3;
    localparam int         WATCHDOG_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         rst_n, pdn, fsync, dc_a, dc_b, sdin;
    logic [W-1:0] tx_a, tx_b;
    logic         sdout_a, oe_a, tsout_a, sdout_b, oe_b, tsout_b;
    logic [W-1:0] ctrl_a, data_a, ctrl_b, data_b;

    logic [W-1:0] exp_ctrl_a, exp_data_a, exp_ctrl_b, exp_data_b;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    tdm_slot_port #(.SLOT_BITS(W), .CTRL_INIT(INIT)) u_tdm_slot_port (
        .bclk(clk), .rst_n(rst_n), .pdn(pdn), .fsync(fsync), .tsin(fsync),
        .dc_sel(dc_a), .sdin(sdin), .tx_data(tx_a), .sdout(sdout_a),
        .sdout_oe(oe_a), .tsout(tsout_a), .ctrl_q(ctrl_a), .data_q(data_a)
    );

    tdm_slot_port #(.SLOT_BITS(W), .CTRL_INIT(INIT)) u_tdm_slot_port_b (
        .bclk(clk), .rst_n(rst_n), .pdn(pdn), .fsync(fsync), .tsin(tsout_a),
        .dc_sel(dc_b), .sdin(sdin), .tx_data(tx_b), .sdout(sdout_b),
        .sdout_oe(oe_b), .tsout(tsout_b), .ctrl_q(ctrl_b), .data_q(data_b)
    );

    function automatic logic slot_bit(input logic [W-1:0] word, input int idx);
        return word[W-1-idx];
    endfunction

    function automatic logic [4:0] expect_pins(input int i, input logic [W-1:0] la,
                                               input logic [W-1:0] lb);
        logic a_on, b_on, bus;
        a_on = (i < W);
        b_on = (i >= W) && (i < 2*W);
        bus  = a_on ? slot_bit(la, i) : (b_on ? slot_bit(lb, i - W) : 1'b0);
        return {a_on, b_on, (i == W-1), (i == 2*W-1), bus};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check({ctrl_a, data_a, ctrl_b, data_b} == {exp_ctrl_a, exp_data_a, exp_ctrl_b, exp_data_b},
              req, {ctrl_a, data_a, ctrl_b, data_b},
              {exp_ctrl_a, exp_data_a, exp_ctrl_b, exp_data_b});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_ctrl_a = INIT; exp_ctrl_b = INIT;
        exp_data_a = '0;   exp_data_b = '0;
        @(negedge clk);
        check(oe_a == 0 && oe_b == 0 && tsout_a == 0 && tsout_b == 0, "R1 outputs idle",
              {oe_a, oe_b, tsout_a, tsout_b}, 0);
        check_regs("R1 register defaults");
    endtask

    // abort_at < 0: full frame; otherwise fsync re-rises after bit abort_at.
    task automatic run_frame(input logic da, input logic db, input logic [W-1:0] wa,
                             input logic [W-1:0] wb, input int hold, input int abort_at);
        logic [W-1:0] la, lb;
        logic [4:0]   got;
        @(posedge clk);
        #1;
        fsync = 1'b1; dc_a = da; dc_b = db;
        la = da ? tx_a : exp_ctrl_a;
        lb = db ? tx_b : exp_ctrl_b;
        for (int i = 0; i < 2*W; i++) begin
            @(posedge clk);
            #1;
            if (i == W) begin
                if (da) exp_data_a = wa; else exp_ctrl_a = wa;
            end
            fsync = (abort_at >= 0 && i == abort_at) ? 1'b1 : (i + 1 < hold);
            sdin  = (i < W) ? slot_bit(wa, i) : slot_bit(wb, i - W);
            @(negedge clk);
            got = {oe_a, oe_b, tsout_a, tsout_b, (oe_a & sdout_a) | (oe_b & sdout_b)};
            if (abort_at >= 0 && i == abort_at + 1) begin
                check(oe_b == 0 && oe_a == 1, "R6 slot abandoned, first device re-granted",
                      {oe_a, oe_b}, 2'b10);
            end else if (abort_at < 0 || i <= abort_at) begin
                check(got == expect_pins(i, la, lb), "R2/R3/R5/R8 pins in bit period",
                      got, expect_pins(i, la, lb));
            end
        end
        @(posedge clk);
        #1;
        if (abort_at < 0) begin
            if (db) exp_data_b = wb; else exp_ctrl_b = wb;
        end
        @(negedge clk);
        if (abort_at < 0)
            check(oe_a == 0 && oe_b == 0, "R2 bus released after both slots",
                  {oe_a, oe_b}, 0);
        check_regs(abort_at < 0 ? "R4 registers after frame" : "R6 no update after abort");
    endtask

    initial begin
        void'($urandom(32'd20240517));
        rst_n = 1'b0; pdn = 1'b0; fsync = 1'b0; dc_a = 1'b0; dc_b = 1'b0; sdin = 1'b0;
        tx_a = 16'h1234; tx_b = 16'hFEDC;
        do_reset();

        // Directed: data frames, all-ones and all-zeros words.
        run_frame(1'b1, 1'b1, 16'hFFFF, 16'h0000, 1, -1);
        // Control frames: the readback word is the default (R3), then the new one.
        run_frame(1'b0, 1'b0, 16'h8001, 16'h7FFE, 1, -1);
        run_frame(1'b0, 1'b1, 16'h3C3C, 16'h5AA5, 2*W-3, -1);
        // R8: fsync held as long as allowed, in control mode.
        run_frame(1'b0, 1'b0, 16'hC001, 16'h0F0F, 2*W-3, -1);

        // Random frames.
        for (int n = 0; n < 24; n++) begin
            tx_a = W'($urandom); tx_b = W'($urandom);
            run_frame(1'($urandom % 2), 1'($urandom % 2), W'($urandom), W'($urandom),
                      1 + int'($urandom % (2*W-3)), -1);
        end

        // R6: frame sync mid-slot of the second device.
        run_frame(1'b1, 1'b0, 16'h0F0F, 16'h1111, 1, W + 4);
        do_reset();

        // R7: power-down after making the control registers non-default.
        run_frame(1'b0, 1'b0, 16'h00FF, 16'hFF00, 1, -1);
        @(posedge clk);
        #1 pdn = 1'b1;
        @(posedge clk);
        #1;
        exp_ctrl_a = INIT; exp_ctrl_b = INIT;
        @(negedge clk);
        check_regs("R7 power-down restores control defaults");
        check(oe_a == 0 && oe_b == 0, "R7 outputs off in power-down", {oe_a, oe_b}, 0);
        fsync = 1'b1;
        #1;
        check(tsout_a == 1 && tsout_b == 1, "R7 release follows grant (high)",
              {tsout_a, tsout_b}, 2'b11);
        fsync = 1'b0;
        #1;
        check(tsout_a == 0 && tsout_b == 0, "R7 release follows grant (low)",
              {tsout_a, tsout_b}, 0);
        @(posedge clk);
        #1 pdn = 1'b0;
        @(posedge clk);
        run_frame(1'b1, 1'b0, 16'hBEEF, 16'h4321, 3, -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule